// File: doc/BRIEF.md
# Bytewise Saturating SIMD ALU

This block splits a 32-bit word into four independent 8-bit lanes (lane 0 in bits 7:0) and applies one operation to all lanes at once. The operations are minimum, maximum, absolute value, negation, addition, subtraction, a shift whose amount is signed, and bitwise and/or/xor against an immediate. The arithmetic operations run in signed or unsigned lane arithmetic and clip each lane to the lane's range. No carry, borrow or shifted bit crosses a lane boundary.

A 6-bit operation code drives the block. Bits 3:0 select the operation. Bit 4 (0x10) selects unsigned lanes. Bit 5 (0x20) replaces the register lanes of the second operand with an 8-bit immediate that is copied into every lane. The caller supplies both operand words, so register storage and operand indexing stay outside the block. A flag-destination index travels with each issued operation. When that index is below 4, the block reports a flag write whose data byte is all zeros. All results come out of a register one clock after the issue.

Top module: `lane_sat_alu`

## Requirements
- R1: Outputs are registered. When `issue` is high at a rising edge, `result`, `result_valid` and the flag outputs take that operation's values at that edge. When `issue` is low, `result_valid` and `flag_we` go low and `result` keeps its value. During reset all outputs are zero.
- R2: `opcode[3:0]` selects the operation: 0 min, 1 max, 2 abs, 3 neg, 4 add, 5 sub, 6 shift, 7 and, 8 or, 9 xor. Codes 10 to 15 produce a zero result.
- R3: min and max compare each lane pair as signed values when `opcode[4]` is 0 and as unsigned values when it is 1.
- R4: add and sub clip each lane to -128..127 in signed mode and to 0..255 in unsigned mode. Lanes never affect each other.
- R5: abs and neg ignore the second operand. In signed mode, abs(-128) and neg(-128) both give 127. In unsigned mode, abs returns its input and neg returns 0.
- R6: For a shift, the low 4 bits of each second-operand lane form a signed amount. A negative amount shifts left by its magnitude, and the result is truncated to 8 bits (a shift of -8 gives 0). A non-negative amount shifts right: arithmetic in signed mode, logical in unsigned mode.
- R7: When `opcode[5]` is 1, every lane of the second operand for ops 0 to 6 is `imm`, and `src_b` has no effect.
- R8: and/or/xor combine each lane of `src_a` with `imm`. They ignore `src_b` and both `opcode[5:4]` bits.
- R9: An issued operation with `flag_idx` < 4 sets `flag_we` high, sets `flag_sel` to `flag_idx[1:0]` and sets `flag_data` to 0x00. An issued operation with `flag_idx` >= 4 leaves `flag_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Operation present this cycle |
| opcode | input | 6 | [3:0] operation, [4] unsigned, [5] immediate operand |
| src_a | input | 32 | First operand, four lanes |
| src_b | input | 32 | Second operand register word |
| imm | input | 8 | Immediate copied to all lanes |
| flag_idx | input | 3 | Flag destination; values 4 to 7 mean no write |
| result | output | 32 | Registered lane results |
| result_valid | output | 1 | Result belongs to an operation issued in the previous cycle |
| flag_we | output | 1 | Flag write request |
| flag_sel | output | 2 | Flag destination index |
| flag_data | output | 8 | Flag byte, always zero |

## Verification
The cases hardest to reach are the saturation edges of each lane, together with the shift amounts of -8 and 7. Uniform random words reach these only occasionally, and seldom in all four lanes in the same operation. The random stimulus therefore draws each lane from a small pool of edge bytes (0x00, 0x01, 0x7F, 0x80, 0xFF and shift codes 0x7, 0x8, 0xF) about half of the time. Directed vectors then pin down clipping in the signed and unsigned directions and the largest left and right shifts. Random bits in unused opcode positions and in `src_b` check that the immediate and logic operations ignore them.

// File: rtl/lane_sat_pkg.sv
// Shared definitions for the bytewise saturating ALU.
// Assumes the operation code layout: [3:0] op, [4] unsigned, [5] immediate.
package lane_sat_pkg;
    localparam int OPC_W   = 6;
    localparam int OPC_UNS = 4;
    localparam int OPC_IMM = 5;

    typedef enum logic [3:0] {
        LOP_MIN = 4'd0,
        LOP_MAX = 4'd1,
        LOP_ABS = 4'd2,
        LOP_NEG = 4'd3,
        LOP_ADD = 4'd4,
        LOP_SUB = 4'd5,
        LOP_SHF = 4'd6,
        LOP_AND = 4'd7,
        LOP_OR  = 4'd8,
        LOP_XOR = 4'd9
    } lane_op_t;

    // True for the operations that always take the immediate operand.
    function automatic logic is_logic_op(input logic [3:0] code);
        return (code == LOP_AND) || (code == LOP_OR) || (code == LOP_XOR);
    endfunction
endpackage

// File: rtl/lane_operand_sel.sv
// Second-operand selection: the register word, or the immediate copied
// into every lane. Assumes logic ops always want the immediate.
module lane_operand_sel #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [3:0]              op_code,
    input  logic                    use_imm,
    input  logic [LANES*LANE_W-1:0] reg_word,
    input  logic [LANE_W-1:0]       imm_byte,
    output logic [LANES*LANE_W-1:0] opnd_b
);
    import lane_sat_pkg::*;

    // Pick the immediate broadcast or the register operand.
    always_comb begin
        if (use_imm || is_logic_op(op_code))
            opnd_b = {LANES{imm_byte}};
        else
            opnd_b = reg_word;
    end
endmodule

// File: rtl/lane_unit.sv
// One lane of the ALU: combinational, clips arithmetic to the lane range,
// truncates shifts. Assumes LANE_W >= 2.
module lane_unit #(
    parameter int LANE_W = 8
) (
    input  logic [3:0]        op_code,
    input  logic              uns,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y
);
    import lane_sat_pkg::*;

    localparam int XW  = LANE_W + 2;
    localparam int SHW = $clog2(LANE_W) + 1;

    logic signed [XW-1:0] ax, bx, hi_lim, lo_lim, raw;
    logic        [SHW-1:0] amt;
    logic        [SHW-1:0] left_n;
    logic        [LANE_W-1:0] shf;
    logic                  do_clip;

    // Extend both operands for the chosen signedness and pick clip limits.
    always_comb begin
        ax     = uns ? {2'b00, a} : {{2{a[LANE_W-1]}}, a};
        bx     = uns ? {2'b00, b} : {{2{b[LANE_W-1]}}, b};
        hi_lim = uns ? XW'((2 ** LANE_W) - 1) : XW'((2 ** (LANE_W - 1)) - 1);
        lo_lim = uns ? XW'(0) : -XW'(2 ** (LANE_W - 1));
    end

    // Shift by a signed amount taken from the low bits of the lane.
    always_comb begin
        amt    = b[SHW-1:0];
        left_n = -amt;
        if (amt[SHW-1])
            shf = a << left_n;
        else
            shf = LANE_W'(ax >>> amt[SHW-2:0]);
    end

    // Compute the unclipped arithmetic result.
    always_comb begin
        raw     = '0;
        do_clip = 1'b1;
        case (op_code)
            LOP_MIN: raw = (ax < bx) ? ax : bx;
            LOP_MAX: raw = (ax > bx) ? ax : bx;
            LOP_ABS: raw = ax[XW-1] ? -ax : ax;
            LOP_NEG: raw = -ax;
            LOP_ADD: raw = ax + bx;
            LOP_SUB: raw = ax - bx;
            default: do_clip = 1'b0;
        endcase
    end

    // Clip arithmetic, or take the shift/logic result.
    always_comb begin
        if (do_clip) begin
            if (raw > hi_lim)      y = hi_lim[LANE_W-1:0];
            else if (raw < lo_lim) y = lo_lim[LANE_W-1:0];
            else                   y = raw[LANE_W-1:0];
        end else begin
            case (op_code)
                LOP_SHF: y = shf;
                LOP_AND: y = a & b;
                LOP_OR:  y = a | b;
                LOP_XOR: y = a ^ b;
                default: y = '0;
            endcase
        end
    end
endmodule

// File: rtl/lane_sat_alu.sv
// Top of the bytewise saturating ALU: operand select, one lane unit per
// lane, and an output register stage with the flag write request.
// Assumes the caller holds the register file and flag storage.
module lane_sat_alu #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int FIDX_W = 3,
    parameter int FSEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue,
    input  logic [5:0]              opcode,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic [LANE_W-1:0]       imm,
    input  logic [FIDX_W-1:0]       flag_idx,
    output logic [LANES*LANE_W-1:0] result,
    output logic                    result_valid,
    output logic                    flag_we,
    output logic [FSEL_W-1:0]       flag_sel,
    output logic [LANE_W-1:0]       flag_data
);
    import lane_sat_pkg::*;

    localparam int WORD_W    = LANES * LANE_W;
    localparam int FLAG_SLOTS = 2 ** FSEL_W;

    logic [WORD_W-1:0] opnd_b;
    logic [WORD_W-1:0] lane_res;
    logic              want_flag;

    lane_operand_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_opsel (
        .op_code  (opcode[3:0]),
        .use_imm  (opcode[OPC_IMM]),
        .reg_word (src_b),
        .imm_byte (imm),
        .opnd_b   (opnd_b)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_unit #(.LANE_W(LANE_W)) u_lane (
            .op_code (opcode[3:0]),
            .uns     (opcode[OPC_UNS]),
            .a       (src_a[g*LANE_W +: LANE_W]),
            .b       (opnd_b[g*LANE_W +: LANE_W]),
            .y       (lane_res[g*LANE_W +: LANE_W])
        );
    end

    // Decide whether the issued operation writes a flag byte.
    always_comb want_flag = issue && (flag_idx < FIDX_W'(FLAG_SLOTS));

    // Register the lane results and the flag request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
            flag_we      <= 1'b0;
            flag_sel     <= '0;
            flag_data    <= '0;
        end else begin
            result_valid <= issue;
            flag_we      <= want_flag;
            flag_data    <= '0;
            if (issue) result <= lane_res;
            if (want_flag) flag_sel <= flag_idx[FSEL_W-1:0];
        end
    end
endmodule

// File: rtl/lane_sat_alu_chk.sv
// Checker for lane_sat_alu, attached by bind; observes ports only.
module lane_sat_alu_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    issue,
    input logic [5:0]              opcode,
    input logic [LANES*LANE_W-1:0] src_a,
    input logic [LANE_W-1:0]       imm,
    input logic [2:0]              flag_idx,
    input logic [LANES*LANE_W-1:0] result,
    input logic                    result_valid,
    input logic                    flag_we,
    input logic [1:0]              flag_sel,
    input logic [LANE_W-1:0]       flag_data
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> result_valid);
    assert_idle_no_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!result_valid && !flag_we && $stable(result)));
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode[3:0] >= 4'd10) |=> (result == '0));
    assert_uabs_ident_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode[4:0] == 5'h12) |=> (result == $past(src_a)));
    assert_uneg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode[4:0] == 5'h13) |=> (result == '0));
    assert_and_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode[3:0] == 4'd7) |=> ((result & ~{LANES{$past(imm)}}) == '0));
    assert_flag_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !flag_idx[2]) |=> (flag_we && flag_sel == $past(flag_idx[1:0])));
    assert_flag_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && flag_idx[2]) |=> !flag_we);
    assert_flag_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_data == '0));
endmodule

bind lane_sat_alu lane_sat_alu_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (issue),
    .opcode       (opcode),
    .src_a        (src_a),
    .imm          (imm),
    .flag_idx     (flag_idx),
    .result       (result),
    .result_valid (result_valid),
    .flag_we      (flag_we),
    .flag_sel     (flag_sel),
    .flag_data    (flag_data)
);

// File: tb/lane_sat_alu_bench.sv
module lane_sat_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [7:0]  imm = '0;
    logic [2:0]  flag_idx = 3'd7;
    logic [31:0] result;
    logic        result_valid, flag_we;
    logic [1:0]  flag_sel;
    logic [7:0]  flag_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] last_res = '0;
    logic [1:0]  last_sel = '0;

    always #10 clk = ~clk;

    lane_sat_alu u_lane_sat_alu (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .imm(imm), .flag_idx(flag_idx),
        .result(result), .result_valid(result_valid), .flag_we(flag_we),
        .flag_sel(flag_sel), .flag_data(flag_data)
    );

    function automatic int clip(input int v, input bit uns);
        int lo = uns ? 0 : -128;
        int hi = uns ? 255 : 127;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic logic [7:0] lane_ref(input logic [3:0] op, input bit uns,
                                            input logic [7:0] a, input logic [7:0] b);
        int sa = uns ? int'(a) : (a[7] ? int'(a) - 256 : int'(a));
        int sb = uns ? int'(b) : (b[7] ? int'(b) - 256 : int'(b));
        int n;
        case (op)
            4'd0: return 8'(clip(sa < sb ? sa : sb, uns));
            4'd1: return 8'(clip(sa > sb ? sa : sb, uns));
            4'd2: return 8'(clip(sa < 0 ? -sa : sa, uns));
            4'd3: return 8'(clip(-sa, uns));
            4'd4: return 8'(clip(sa + sb, uns));
            4'd5: return 8'(clip(sa - sb, uns));
            4'd6: begin
                n = b[3] ? int'(b[3:0]) - 16 : int'(b[3:0]);
                if (n < 0) return 8'((sa << (-n)) & 255);
                return 8'((sa >>> n) & 255);
            end
            4'd7: return a & b;
            4'd8: return a | b;
            4'd9: return a ^ b;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] word_ref(input logic [5:0] opc, input logic [31:0] a,
                                             input logic [31:0] b, input logic [7:0] im);
        logic [31:0] bb;
        logic [31:0] r;
        bb = (opc[5] || opc[3:0] == 4'd7 || opc[3:0] == 4'd8 || opc[3:0] == 4'd9)
             ? {4{im}} : b;
        for (int i = 0; i < 4; i++)
            r[i*8 +: 8] = lane_ref(opc[3:0], opc[4], a[i*8 +: 8], bb[i*8 +: 8]);
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return "R5";
            4'd4, 4'd5: return "R4";
            4'd6: return "R6";
            4'd7, 4'd8, 4'd9: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, check it at the next falling edge.
    task automatic run(input bit iss, input logic [5:0] opc, input logic [31:0] a,
                       input logic [31:0] b, input logic [7:0] im, input logic [2:0] fi,
                       input string tag);
        logic [31:0] exp;
        issue = iss; opcode = opc; src_a = a; src_b = b; imm = im; flag_idx = fi;
        @(negedge clk);
        exp = iss ? word_ref(opc, a, b, im) : last_res;
        check(iss ? {tag.len() > 0 ? tag : req_of(opc[3:0])} : "R1", result, exp);
        check("R1", {31'd0, result_valid}, {31'd0, iss});
        check("R9", {31'd0, flag_we}, {31'd0, iss && !fi[2]});
        if (iss && !fi[2]) begin
            check("R9", {30'd0, flag_sel}, {30'd0, fi[1:0]});
            last_sel = fi[1:0];
        end
        if (flag_we) check("R9", {24'd0, flag_data}, 32'd0);
        last_res = exp;
    endtask

    function automatic logic [7:0] pick_byte();
        logic [7:0] pool [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h07, 8'h08, 8'h0F};
        if ($urandom_range(1, 0) == 0) return pool[$urandom_range(7, 0)];
        return 8'($urandom());
    endfunction

    initial begin
        #4_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (2) @(negedge clk);
        check("R1", result, 32'd0);
        check("R1", {29'd0, result_valid, flag_we, |flag_data}, 32'd0);
        rst_n = 1'b1;
        // Directed corners
        run(1, 6'h04, 32'h7F80_FF7F, 32'h0180_FF01, 8'h00, 3'd0, "R4");
        check("R4", result, 32'h7F80_FE7F);
        run(1, 6'h14, 32'hFF00_80FF, 32'h0100_8001, 8'h00, 3'd1, "R4");
        check("R4", result, 32'hFF00_FFFF);
        run(1, 6'h05, 32'h8000_7F80, 32'h0101_FF01, 8'h00, 3'd2, "R4");
        check("R4", result, 32'h80FF_7F80);
        run(1, 6'h15, 32'h0010_0500, 32'h0105_0601, 8'h00, 3'd3, "R4");
        check("R4", result, 32'h000B_0000);
        run(1, 6'h02, 32'h8081_7F00, 32'hFFFF_FFFF, 8'h00, 3'd4, "R5");
        check("R5", result, 32'h7F7F_7F00);
        run(1, 6'h03, 32'h8001_7F00, 32'h1234_5678, 8'h00, 3'd7, "R5");
        check("R5", result, 32'h7FFF_8100);
        run(1, 6'h13, 32'h80FF_0100, 32'h0, 8'h00, 3'd0, "R5");
        run(1, 6'h12, 32'h80FF_0100, 32'hAAAA_AAAA, 8'h00, 3'd0, "R5");
        run(1, 6'h06, 32'h8080_0181, 32'h0707_0808, 8'h00, 3'd1, "R6");
        check("R6", result, 32'hFFFF_0000);
        run(1, 6'h16, 32'h8080_03FF, 32'h0700_0F0F, 8'h00, 3'd1, "R6");
        check("R6", result, 32'h0180_06FE);
        run(1, 6'h00, 32'h80FF_017F, 32'h7F00_0280, 8'h00, 3'd5, "R3");
        check("R3", result, 32'h80FF_0180);
        run(1, 6'h11, 32'h80FF_017F, 32'h7F00_0280, 8'h00, 3'd5, "R3");
        check("R3", result, 32'h80FF_0280);
        run(1, 6'h24, 32'h0102_7F03, 32'hFFFF_FFFF, 8'h10, 3'd6, "R7");
        check("R7", result, 32'h1112_7F13);
        run(1, 6'h37, 32'hF0F0_0F0F, 32'h0, 8'h3C, 3'd0, "R8");
        check("R8", result, 32'h3030_0C0C);
        run(1, 6'h08, 32'h0102_0304, 32'hFFFF_FFFF, 8'h80, 3'd2, "R8");
        run(1, 6'h19, 32'hFF00_FF00, 32'h1234_5678, 8'h0F, 3'd3, "R8");
        run(1, 6'h0C, 32'h1234_5678, 32'h1111_1111, 8'h55, 3'd0, "R2");
        run(0, 6'h04, 32'h1111_1111, 32'h1111_1111, 8'h00, 3'd0, "R1");
        // Random vectors
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a, b;
            logic [5:0]  opc;
            for (int i = 0; i < 4; i++) begin
                a[i*8 +: 8] = pick_byte();
                b[i*8 +: 8] = pick_byte();
            end
            opc = {2'($urandom()), ($urandom_range(15, 0) < 13) ?
                   4'($urandom_range(9, 0)) : 4'($urandom_range(15, 10))};
            run($urandom_range(7, 0) != 0, opc, a, b, pick_byte(),
                3'($urandom()), "");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule